// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a flash-style asynchronous write bus and the program/erase engine of a memory. It samples the chip-enable and write-enable strobes on the system clock and turns each completed write into one bus cycle. The address of a cycle is taken when the later of the two strobes goes low. The data is taken from the last clock edge at which both strobes were still low. A chain of these cycles is then matched against a small set of instructions: read/reset, identifier read, program, block erase, chip erase, erase suspend and erase resume.

Every instruction except reset, suspend and resume has to begin with two unlock cycles at fixed addresses. Those addresses depend on whether the bus is organised by bytes or by words. Any cycle that does not fit the expected step sends the decoder back to plain array reads and issues nothing. A recognised program or erase comes out as a one-clock request that carries the address and data of the final cycle. While the identifier read mode is active, the decoder returns a fixed manufacturer code and a device code on reads.

Top module: `unlock_cmd_decoder`

## Requirements
- R1: While reset is high and on the cycle after it, every request output is low and `asel_active` is low. After reset the decoder waits for a first unlock cycle.
- R2: The sequence AAh@U1, 55h@U2, A0h@U1, then any write (A, D) raises `prog_req` for exactly one clock, with `req_addr`=A and `req_data`=D. The pulse appears on the clock after the edge at which that final write ends.
- R3: In word mode (`byte_mode`=0) U1 is 555h and U2 is 2AAh. In byte mode U1 is AAAh and U2 is 555h. Only the low 12 address bits and the low 8 data bits are compared. Unlock cycles that use the other mode's addresses are not accepted.
- R4: A cycle whose address or data does not match the expected step returns the decoder to read-array and issues no request.
- R5: AAh@U1, 55h@U2, 80h@U1, AAh@U1, 55h@U2, then 30h at any address A pulses `blk_erase_req` once with `req_addr`=A.
- R6: The same five setup cycles followed by 10h@U1 pulse `chip_erase_req` once. 10h at any other address issues nothing.
- R7: AAh@U1, 55h@U2, 90h@U1 set `asel_active`. While it is set, `id_data` is 20h at address 0 and the device code at address 1 (word mode) or address 2 (byte mode). The device code is 5Bh when BOTTOM_BOOT=1 and D7h otherwise. Every other address reads 0. Outside this mode `id_data` is 0. A write of F0h at any address clears the mode.
- R8: While `busy` is high, a cycle starting a new instruction is ignored and the state is kept. A write of B0h (any address) pulses `suspend_req` once.
- R9: With `busy` low, a single write of 30h at any address from read-array pulses `resume_req` once.
- R10: A write cycle during which `lockout` is high at any sampled clock edge, including the edge at which the cycle ends, is ignored. It changes neither the state nor the outputs.
- R11: The request address is the address present when the later strobe fell. The request data is the value present at the last edge with both strobes low. Later changes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_mode | input | 1 | 1 selects byte-organised address coding |
| lockout | input | 1 | Supply lockout; write cycles are dropped while high |
| busy | input | 1 | Program/erase engine is running |
| addr_in | input | AW | Bus address |
| data_in | input | DW | Bus write data |
| prog_req | output | 1 | One-clock program request |
| blk_erase_req | output | 1 | One-clock block erase request |
| chip_erase_req | output | 1 | One-clock chip erase request |
| suspend_req | output | 1 | One-clock erase suspend request |
| resume_req | output | 1 | One-clock erase resume request |
| req_addr | output | AW | Address of the last accepted write cycle |
| req_data | output | DW | Data of the last accepted write cycle |
| asel_active | output | 1 | Identifier read mode is active |
| id_data | output | DW | Identifier code for `addr_in` |

## Verification
The conflict that matters is the supply lockout rising on the very clock edge at which the final program cycle ends. The bench raises `lockout` together with `we_n` for the fourth write of a program sequence. It requires that no program pulse appears and that the decoder stays armed, so a following clean write still produces the request. The per-clock reference model applies the same rule to every cycle of the run. A second overlap is a read of the identifier address in the same clock as the decoder leaves identifier mode. There `id_data` must drop to 0 on the same clock as `asel_active`.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

    localparam int CMP_W = 12;

    typedef enum logic [2:0] {
        ST_READ, ST_UNL1, ST_UNL2, ST_PGM,
        ST_ESET, ST_EUNL1, ST_EUNL2, ST_ASEL
    } dec_state_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_PROG, OP_BLK, OP_CHIP, OP_SUSP, OP_RES
    } op_e;

    localparam logic [7:0] C_KEY_A   = 8'hAA;
    localparam logic [7:0] C_KEY_B   = 8'h55;
    localparam logic [7:0] C_ASEL    = 8'h90;
    localparam logic [7:0] C_PGM     = 8'hA0;
    localparam logic [7:0] C_ESET    = 8'h80;
    localparam logic [7:0] C_RESET   = 8'hF0;
    localparam logic [7:0] C_SUSP    = 8'hB0;
    localparam logic [7:0] C_RESUME  = 8'h30;
    localparam logic [7:0] C_BLK     = 8'h30;
    localparam logic [7:0] C_CHIP    = 8'h10;
    localparam logic [7:0] ID_MFR    = 8'h20;
    localparam logic [7:0] ID_DEV_B  = 8'h5B;
    localparam logic [7:0] ID_DEV_T  = 8'hD7;

    // Unlock address for the first (second=0) or second key cycle
    function automatic logic [CMP_W-1:0] key_addr(input logic byte_mode, input logic second);
        if (byte_mode) return second ? 12'h555 : 12'hAAA;
        else           return second ? 12'h2AA : 12'h555;
    endfunction

endpackage

// File: rtl/ucd_bus_capture.sv
module ucd_bus_capture #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          lockout,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          wr_done,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    logic act, act_q, lk_seen;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;

    assign act = !ce_n && !we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q   <= 1'b0;
            lk_seen <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            act_q <= act;
            if (act && !act_q) begin
                addr_q  <= addr_in;
                lk_seen <= lockout;
            end else if (act) begin
                lk_seen <= lk_seen | lockout;
            end
            if (act) data_q <= data_in;
        end
    end

    assign wr_done = act_q && !act && !lockout && !lk_seen;
    assign wr_addr = addr_q;
    assign wr_data = data_q;
endmodule

// File: rtl/ucd_cmd_fsm.sv
module ucd_cmd_fsm
    import ucd_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_done,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          byte_mode,
    input  logic          busy,
    output dec_state_e    state,
    output op_e           op,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data
);
    dec_state_e nxt;
    op_e        nop;
    logic       k1, k2;
    logic [7:0] code;

    assign code = wr_data[7:0];
    assign k1   = wr_addr[CMP_W-1:0] == key_addr(byte_mode, 1'b0);
    assign k2   = wr_addr[CMP_W-1:0] == key_addr(byte_mode, 1'b1);

    always_comb begin
        nxt = state;
        nop = OP_NONE;
        if (wr_done) begin
            case (state)
                ST_READ, ST_ASEL: begin
                    if (code == C_RESET) nxt = ST_READ;
                    else if (busy) begin
                        if (code == C_SUSP) nop = OP_SUSP;
                    end else if (code == C_KEY_A && k1) nxt = ST_UNL1;
                    else begin
                        nxt = ST_READ;
                        if (code == C_RESUME) nop = OP_RES;
                    end
                end
                ST_UNL1:  nxt = (code == C_KEY_B && k2) ? ST_UNL2 : ST_READ;
                ST_UNL2: begin
                    nxt = ST_READ;
                    if (k1 && code == C_ASEL) nxt = ST_ASEL;
                    else if (k1 && code == C_PGM) nxt = ST_PGM;
                    else if (k1 && code == C_ESET) nxt = ST_ESET;
                end
                ST_PGM: begin
                    nop = OP_PROG;
                    nxt = ST_READ;
                end
                ST_ESET:  nxt = (code == C_KEY_A && k1) ? ST_EUNL1 : ST_READ;
                ST_EUNL1: nxt = (code == C_KEY_B && k2) ? ST_EUNL2 : ST_READ;
                ST_EUNL2: begin
                    nxt = ST_READ;
                    if (code == C_BLK) nop = OP_BLK;
                    else if (code == C_CHIP && k1) nop = OP_CHIP;
                end
                default:  nxt = ST_READ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_READ;
            op      <= OP_NONE;
            op_addr <= '0;
            op_data <= '0;
        end else begin
            state <= nxt;
            op    <= nop;
            if (wr_done) begin
                op_addr <= wr_addr;
                op_data <= wr_data;
            end
        end
    end
endmodule

// File: rtl/ucd_id_rom.sv
module ucd_id_rom
    import ucd_pkg::*;
#(
    parameter int AW          = 20,
    parameter int DW          = 16,
    parameter bit BOTTOM_BOOT = 1'b1
) (
    input  logic          asel,
    input  logic          byte_mode,
    input  logic [AW-1:0] addr_in,
    output logic [DW-1:0] id_data
);
    localparam logic [7:0] DEV_CODE = BOTTOM_BOOT ? ID_DEV_B : ID_DEV_T;
    logic [AW-1:0] dev_loc;

    assign dev_loc = byte_mode ? AW'(2) : AW'(1);

    always_comb begin
        id_data = '0;
        if (asel) begin
            if (addr_in == '0)          id_data = DW'(ID_MFR);
            else if (addr_in == dev_loc) id_data = DW'(DEV_CODE);
        end
    end
endmodule

// File: rtl/unlock_cmd_decoder.sv
module unlock_cmd_decoder
    import ucd_pkg::*;
#(
    parameter int AW          = 20,
    parameter int DW          = 16,
    parameter bit BOTTOM_BOOT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          byte_mode,
    input  logic          lockout,
    input  logic          busy,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          prog_req,
    output logic          blk_erase_req,
    output logic          chip_erase_req,
    output logic          suspend_req,
    output logic          resume_req,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_data,
    output logic          asel_active,
    output logic [DW-1:0] id_data
);
    logic          wr_done;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    dec_state_e    state;
    op_e           op;

    ucd_bus_capture #(.AW(AW), .DW(DW)) u_cap (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .lockout(lockout),
        .addr_in(addr_in), .data_in(data_in),
        .wr_done(wr_done), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    ucd_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst(rst), .wr_done(wr_done), .wr_addr(wr_addr),
        .wr_data(wr_data), .byte_mode(byte_mode), .busy(busy),
        .state(state), .op(op), .op_addr(req_addr), .op_data(req_data)
    );

    assign asel_active = (state == ST_ASEL);

    ucd_id_rom #(.AW(AW), .DW(DW), .BOTTOM_BOOT(BOTTOM_BOOT)) u_id (
        .asel(asel_active), .byte_mode(byte_mode), .addr_in(addr_in),
        .id_data(id_data)
    );

    assign prog_req       = (op == OP_PROG);
    assign blk_erase_req  = (op == OP_BLK);
    assign chip_erase_req = (op == OP_CHIP);
    assign suspend_req    = (op == OP_SUSP);
    assign resume_req     = (op == OP_RES);
endmodule

// File: rtl/unlock_cmd_decoder_chk.sv
module unlock_cmd_decoder_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          lockout,
    input logic          busy,
    input logic          prog_req,
    input logic          blk_erase_req,
    input logic          chip_erase_req,
    input logic          suspend_req,
    input logic          resume_req,
    input logic          asel_active,
    input logic [DW-1:0] id_data
);
    logic any_req;
    assign any_req = prog_req | blk_erase_req | chip_erase_req | suspend_req | resume_req;

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!any_req && !asel_active));

    p_prog_single_r2: assert property (@(posedge clk) disable iff (rst)
        prog_req |=> !prog_req);

    p_idle_id_r7: assert property (@(posedge clk) disable iff (rst)
        !asel_active |-> (id_data == '0));

    p_busy_no_resume_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> !resume_req);

    p_lockout_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        lockout |=> !any_req);
endmodule

bind unlock_cmd_decoder unlock_cmd_decoder_chk #(.DW(DW)) u_chk (.*);

// File: tb/unlock_cmd_decoder_test.sv
module unlock_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, byte_mode = 1'b0, lockout = 1'b0, busy = 1'b0;
    logic [19:0] addr_in = '0;
    logic [15:0] data_in = '0;
    logic        prog_req, blk_erase_req, chip_erase_req, suspend_req, resume_req, asel_active;
    logic [19:0] req_addr;
    logic [15:0] req_data, id_data;

    int n_chk = 0, n_fail = 0;
    int n_prog = 0, n_blk = 0, n_chip = 0, n_susp = 0, n_res = 0;
    logic [19:0] cap_addr;
    logic [15:0] cap_data;
    bit done = 0;

    always #4 clk = ~clk;

    unlock_cmd_decoder uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    int          ph = 0;
    bit          m_act = 0, m_lk = 0;
    logic [19:0] m_a = '0;
    logic [15:0] m_d = '0;
    bit e_prog, e_blk, e_chip, e_susp, e_res;
    logic [19:0] e_addr;
    logic [15:0] e_data;

    always @(posedge clk) begin
        bit act, fin;
        int u1, u2, am, cd;
        e_prog = 0; e_blk = 0; e_chip = 0; e_susp = 0; e_res = 0;
        if (rst) begin
            ph = 0; m_act = 0; m_lk = 0;
        end else begin
            act = !ce_n && !we_n;
            fin = m_act && !act && !lockout && !m_lk;
            if (act && !m_act) begin m_a = addr_in; m_lk = lockout; end
            else if (act) m_lk = m_lk | lockout;
            if (act) m_d = data_in;
            if (fin) begin
                u1 = byte_mode ? 'hAAA : 'h555;
                u2 = byte_mode ? 'h555 : 'h2AA;
                am = m_a % 4096;
                cd = m_d % 256;
                e_addr = m_a; e_data = m_d;
                if (ph == 0 || ph == 7) begin
                    if (cd == 'hF0) ph = 0;
                    else if (busy) begin if (cd == 'hB0) e_susp = 1; end
                    else if (cd == 'hAA && am == u1) ph = 1;
                    else begin ph = 0; if (cd == 'h30) e_res = 1; end
                end else if (ph == 1) ph = (cd == 'h55 && am == u2) ? 2 : 0;
                else if (ph == 2) begin
                    if (am == u1 && cd == 'h90) ph = 7;
                    else if (am == u1 && cd == 'hA0) ph = 3;
                    else if (am == u1 && cd == 'h80) ph = 4;
                    else ph = 0;
                end else if (ph == 3) begin e_prog = 1; ph = 0; end
                else if (ph == 4) ph = (cd == 'hAA && am == u1) ? 5 : 0;
                else if (ph == 5) ph = (cd == 'h55 && am == u2) ? 6 : 0;
                else begin
                    if (cd == 'h30) e_blk = 1;
                    else if (cd == 'h10 && am == u1) e_chip = 1;
                    ph = 0;
                end
            end
            m_act = act;
        end
    end

    // Per-clock comparison and pulse bookkeeping
    always @(negedge clk) begin
        logic [15:0] e_id;
        #2;
        if (!rst && !done) begin
            e_id = 0;
            if (ph == 7) begin
                if (addr_in == 0) e_id = 16'h20;
                else if (addr_in == (byte_mode ? 2 : 1)) e_id = 16'h5B;
            end
            chk("R2 prog_req", prog_req, e_prog);
            chk("R5 blk_erase_req", blk_erase_req, e_blk);
            chk("R6 chip_erase_req", chip_erase_req, e_chip);
            chk("R8 suspend_req", suspend_req, e_susp);
            chk("R9 resume_req", resume_req, e_res);
            chk("R7 asel_active", asel_active, ph == 7);
            chk("R7 id_data", id_data, e_id);
            if (e_prog || e_blk || e_chip) begin
                chk("R11 req_addr", req_addr, e_addr);
                chk("R11 req_data", req_data, e_data);
            end
            if (prog_req)       n_prog++;
            if (blk_erase_req)  n_blk++;
            if (chip_erase_req) n_chip++;
            if (suspend_req)    n_susp++;
            if (resume_req)     n_res++;
            if (prog_req | blk_erase_req | chip_erase_req) begin
                cap_addr = req_addr; cap_data = req_data;
            end
        end
    end

    task automatic wr(input logic [19:0] a, input logic [15:0] d);
        @(negedge clk); addr_in = a; data_in = d; ce_n = 0;
        @(negedge clk); we_n = 0;
        @(negedge clk);
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #3;
    endtask

    task automatic unlock(input bit bm);
        wr(bm ? 20'hAAA : 20'h555, 16'hAA);
        wr(bm ? 20'h555 : 20'h2AA, 16'h55);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 prog_req after reset", prog_req, 0);
        chk("R1 asel_active after reset", asel_active, 0);
        rst = 0;
        settle();
        chk("R1 no request idle", prog_req | blk_erase_req | chip_erase_req, 0);

        // R2 word-mode program
        unlock(0); wr(20'h555, 16'hA0); wr(20'h12345, 16'hBEEF); settle();
        chk("R2 program count", n_prog, 1);
        chk("R2 program addr", cap_addr, 20'h12345);
        chk("R2 program data", cap_data, 16'hBEEF);

        // R3 byte mode: byte keys work, word keys do not
        byte_mode = 1;
        unlock(1); wr(20'hAAA, 16'hA0); wr(20'h00040, 16'h1234); settle();
        chk("R3 byte program count", n_prog, 2);
        chk("R3 byte program addr", cap_addr, 20'h00040);
        unlock(0); wr(20'h555, 16'hA0); wr(20'h00050, 16'h4321); settle();
        chk("R3 word keys rejected in byte mode", n_prog, 2);
        byte_mode = 0;

        // R4 mismatch on the second key data
        wr(20'h555, 16'hAA); wr(20'h2AA, 16'h54); wr(20'h555, 16'hA0); wr(20'h00060, 16'h9999);
        settle();
        chk("R4 aborted sequence", n_prog, 2);

        // R5 block erase
        unlock(0); wr(20'h555, 16'h80); unlock(0); wr(20'h30000, 16'h30); settle();
        chk("R5 block erase count", n_blk, 1);
        chk("R5 block erase addr", cap_addr, 20'h30000);

        // R6 chip erase, correct and wrong address
        unlock(0); wr(20'h555, 16'h80); unlock(0); wr(20'h555, 16'h10); settle();
        chk("R6 chip erase count", n_chip, 1);
        unlock(0); wr(20'h555, 16'h80); unlock(0); wr(20'h100, 16'h10); settle();
        chk("R6 chip erase wrong addr", n_chip, 1);

        // R7 identifier read, word then byte
        unlock(0); wr(20'h555, 16'h90); settle();
        chk("R7 mode entered", asel_active, 1);
        @(negedge clk); addr_in = 20'h0; #2; chk("R7 manufacturer", id_data, 16'h20);
        @(negedge clk); addr_in = 20'h1; #2; chk("R7 device word", id_data, 16'h5B);
        @(negedge clk); addr_in = 20'h5; #2; chk("R7 other addr", id_data, 16'h0);
        wr(20'h1, 16'hF0); settle();
        chk("R7 reset leaves mode", asel_active, 0);
        byte_mode = 1;
        unlock(1); wr(20'hAAA, 16'h90);
        @(negedge clk); addr_in = 20'h2; #2; chk("R7 device byte", id_data, 16'h5B);
        wr(20'h2, 16'hF0); settle();
        chk("R7 byte mode exit", id_data, 16'h0);
        byte_mode = 0;

        // R8 busy blocks instructions, suspend passes
        busy = 1;
        unlock(0); wr(20'h555, 16'hA0); wr(20'h00070, 16'h7777); settle();
        chk("R8 busy blocks program", n_prog, 2);
        wr(20'h00123, 16'hB0); settle();
        chk("R8 suspend count", n_susp, 1);
        busy = 0;

        // R9 resume
        wr(20'h00456, 16'h30); settle();
        chk("R9 resume count", n_res, 1);

        // R10 lockout held for a whole sequence
        lockout = 1;
        unlock(0); wr(20'h555, 16'hA0); wr(20'h00080, 16'h8888); settle();
        chk("R10 lockout ignores writes", n_prog, 2);
        lockout = 0;

        // R10 lockout rising on the edge the final write ends
        unlock(0); wr(20'h555, 16'hA0);
        @(negedge clk); addr_in = 20'h00090; data_in = 16'h1111; ce_n = 0;
        @(negedge clk); we_n = 0;
        @(negedge clk);
        @(negedge clk); we_n = 1; lockout = 1;
        @(negedge clk); ce_n = 1;
        @(negedge clk); lockout = 0;
        settle();
        chk("R10 dropped final write", n_prog, 2);
        wr(20'h02000, 16'h55AA); settle();
        chk("R10 still armed after drop", n_prog, 3);
        chk("R10 armed addr", cap_addr, 20'h02000);

        // R11 address at later fall, data at last active edge
        unlock(0); wr(20'h555, 16'hA0);
        @(negedge clk); addr_in = 20'h0AAAA; data_in = 16'h0001; ce_n = 0;
        @(negedge clk); addr_in = 20'h0BBBB; we_n = 0;
        @(negedge clk); addr_in = 20'h0CCCC; data_in = 16'h0D01;
        @(negedge clk); data_in = 16'h0D02;
        @(negedge clk); we_n = 1; addr_in = 20'h0EEEE; data_in = 16'h0D03;
        @(negedge clk); ce_n = 1;
        settle();
        chk("R11 latched addr", cap_addr, 20'h0BBBB);
        chk("R11 latched data", cap_data, 16'h0D02);

        repeat (4) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule